// File: doc/BRIEF.md
# Serial Clock Generator with Rate-Settled Flag

This block derives the serial clock of a flash-oriented SPI controller from a faster base clock. One 16-bit control register carries a clock enable, an 8-bit divider and a read-only flag that tells software the serial clock is running at the rate it last programmed. The serial clock runs at the base frequency divided by twice the divider. Each half of the serial clock lasts exactly `divider` base cycles. A divider of zero is treated as one.

When software writes a different divider, the flag drops in the next cycle. The period already in progress finishes at the old rate. The new rate is loaded only at a period boundary, so no shortened pulse reaches the output. The flag rises again after two complete periods have run at the new rate, and software polls for it. The block also produces a one-cycle bit-tick strobe for the shifter at the start of every serial clock period. A polarity input selects the idle level of the clock.

Top module: `serclk_gen`

## Requirements
- R1: Register layout: bit 0 is the clock enable and bits 15:8 are the divider. Both read back as written. Bit 1 reads the stable flag, and writes to it are ignored. Bits 7:2 read as 0. After reset the register reads 16'h0100: divider 1, enable 0, flag 0.
- R2: While the enable bit is 0, `sclk` sits at the level of `cpol` and `bit_tick` stays low. Both take effect within two cycles of clearing the enable.
- R3: While enabled with effective divider D, each serial clock period begins with D base cycles at the idle level, followed by D base cycles at the opposite level.
- R4: A divider value of 0 produces the same waveform as a divider of 1.
- R5: `bit_tick` is high for exactly one base cycle per period: the first cycle in which `sclk` is back at its idle level.
- R6: After a divider change, every observed half period has the old length or the new length, and no half of the old length follows one of the new length.
- R7: A write whose divider field differs from the stored one makes the stable flag read 0 in the next cycle. A write with an unchanged divider leaves the flag as it was.
- R8: After a divider change, the stable flag rises in the cycle after the second `bit_tick` that ends a full period at the new rate. This happens no later than 2·Dold + 4·Dnew + 6 cycles after the write. While the flag is set, the active rate equals the programmed rate.
- R9: Setting `cpol` to 1 inverts `sclk`, so the idle level is high. Period timing is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write value |
| rd_data | output | 16 | Register read value |
| cpol | input | 1 | Idle level of the serial clock |
| sclk | output | 1 | Serial clock |
| bit_tick | output | 1 | One-cycle strobe at the start of each period |

## Verification
The hardest situation to reach from the ports is a divider write that lands while a period at the old rate is still running, including a write that falls on the very edge that ends a period. In that case the flag must not count the old-rate period that follows. The stimulus reprograms the divider at random points in the period with random old and new values, including zero and equal values. It records every half-period length and tick interval until the flag returns. Directed cases cover the largest divider, rewriting the same value, polarity inversion and disabling the clock in the middle of a period.

// File: rtl/serclk_pkg.sv
// Shared register geometry for the serial clock generator.
// Assumes a 16-bit control register; the field positions are the ones software decodes.
package serclk_pkg;
    localparam int REG_W      = 16;
    localparam int DIV_W      = 8;
    localparam int EN_BIT     = 0;
    localparam int STABLE_BIT = 1;
    localparam int DIV_LSB    = 8;
    localparam int SETTLE_N   = 2;
endpackage

// File: rtl/serclk_regs.sv
// Control register: holds the enable bit and the raw divider field.
// Flags a write that changes the divider and presents the effective divider (0 becomes 1).
// Assumes a single-cycle write strobe; the readback is combinational.
module serclk_regs
    import serclk_pkg::*;
#(
    parameter int RW = REG_W,
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [RW-1:0] wr_data,
    input  logic          stable,
    output logic [RW-1:0] rd_data,
    output logic          en,
    output logic [DW-1:0] div_eff,
    output logic          div_change
);
    logic [DW-1:0] div_q;
    logic [DW-1:0] wr_div;

    assign wr_div = wr_data[DIV_LSB +: DW];

    // Capture the enable bit and the divider on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en    <= 1'b0;
            div_q <= DW'(1);
        end else if (wr_en) begin
            en    <= wr_data[EN_BIT];
            div_q <= wr_div;
        end
    end

    // Raise a pulse when the incoming divider differs from the stored one.
    always_comb div_change = wr_en && (wr_div != div_q);

    // Map a zero divider to one so that the clock never stalls.
    always_comb div_eff = (div_q == '0) ? DW'(1) : div_q;

    // Assemble the readback word.
    always_comb begin
        rd_data                 = '0;
        rd_data[EN_BIT]         = en;
        rd_data[STABLE_BIT]     = stable;
        rd_data[DIV_LSB +: DW]  = div_q;
    end
endmodule

// File: rtl/serclk_phase.sv
// Half-period counter and phase toggle of the serial clock.
// Loads the programmed divider only at a full-period boundary, or freely while disabled.
// Reports each boundary, and whether that boundary switched the rate, as registered pulses.
module serclk_phase
    import serclk_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [DW-1:0] div_eff,
    output logic          phase,
    output logic [DW-1:0] act_div,
    output logic          period_done,
    output logic          rate_switched
);
    logic [DW-1:0] cnt;
    logic          half_end;

    // Detect the last base cycle of the current half period.
    always_comb half_end = (cnt == act_div - DW'(1));

    // Advance the counter, toggle the phase, and reload the rate at the period end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt           <= '0;
            phase         <= 1'b0;
            act_div       <= DW'(1);
            period_done   <= 1'b0;
            rate_switched <= 1'b0;
        end else if (!en) begin
            cnt           <= '0;
            phase         <= 1'b0;
            act_div       <= div_eff;
            period_done   <= 1'b0;
            rate_switched <= 1'b0;
        end else begin
            period_done   <= 1'b0;
            rate_switched <= 1'b0;
            if (half_end) begin
                cnt   <= '0;
                phase <= ~phase;
                if (phase) begin
                    period_done   <= 1'b1;
                    rate_switched <= (act_div != div_eff);
                    act_div       <= div_eff;
                end
            end else begin
                cnt <= cnt + DW'(1);
            end
        end
    end
endmodule

// File: rtl/serclk_settle.sv
// Counts full periods run at the programmed rate and reports when the clock has settled.
// Restarts on a divider-changing write, while the active and programmed rates differ,
// and at the boundary that switches the rate.
module serclk_settle
    import serclk_pkg::*;
#(
    parameter int DW = DIV_W,
    parameter int N  = SETTLE_N,
    localparam int CW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          div_change,
    input  logic [DW-1:0] act_div,
    input  logic [DW-1:0] div_eff,
    input  logic          period_done,
    input  logic          rate_switched,
    output logic          stable
);
    logic [CW-1:0] good_periods;

    // Count the clean periods at the current rate, saturating at N.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            good_periods <= '0;
        end else if (div_change || (act_div != div_eff) || (period_done && rate_switched)) begin
            good_periods <= '0;
        end else if (period_done && (good_periods != CW'(N))) begin
            good_periods <= good_periods + CW'(1);
        end
    end

    // The rate counts as settled once N clean periods have run.
    always_comb stable = (good_periods == CW'(N));
endmodule

// File: rtl/serclk_gen.sv
// Serial clock generator: divides the base clock by twice the divider, applies polarity,
// strobes a tick at the start of each period, and reports when a new rate has settled.
// Assumes one clock domain and a synchronous active-low reset.
module serclk_gen
    import serclk_pkg::*;
#(
    parameter int RW = REG_W,
    parameter int DW = DIV_W,
    parameter int N  = SETTLE_N
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [RW-1:0] wr_data,
    output logic [RW-1:0] rd_data,
    input  logic          cpol,
    output logic          sclk,
    output logic          bit_tick
);
    logic          en;
    logic [DW-1:0] div_eff;
    logic          div_change;
    logic          stable;
    logic          phase;
    logic [DW-1:0] act_div;
    logic          period_done;
    logic          rate_switched;

    serclk_regs #(.RW(RW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .stable(stable), .rd_data(rd_data), .en(en),
        .div_eff(div_eff), .div_change(div_change)
    );

    serclk_phase #(.DW(DW)) u_phase (
        .clk(clk), .rst_n(rst_n), .en(en), .div_eff(div_eff),
        .phase(phase), .act_div(act_div),
        .period_done(period_done), .rate_switched(rate_switched)
    );

    serclk_settle #(.DW(DW), .N(N)) u_settle (
        .clk(clk), .rst_n(rst_n), .div_change(div_change),
        .act_div(act_div), .div_eff(div_eff),
        .period_done(period_done), .rate_switched(rate_switched),
        .stable(stable)
    );

    // Apply the polarity to the phase; the tick marks the return to the idle level.
    always_comb begin
        sclk     = phase ^ cpol;
        bit_tick = period_done;
    end
endmodule

// File: rtl/serclk_gen_chk.sv
// Property checker for the serial clock generator, attached by bind.
module serclk_gen_chk
    import serclk_pkg::*;
#(
    parameter int RW = REG_W,
    parameter int DW = DIV_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [RW-1:0] wr_data,
    input logic [RW-1:0] rd_data,
    input logic          cpol,
    input logic          sclk,
    input logic          bit_tick,
    input logic [DW-1:0] act_div,
    input logic [DW-1:0] div_eff
);
    // R2: after the enable has been clear for two samples, the clock is idle and the tick is quiet.
    assert_idle_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[EN_BIT] && !$past(rd_data[EN_BIT])) |-> (sclk == cpol && !bit_tick));

    // R5: the tick lasts one cycle.
    assert_tick_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> !bit_tick);

    // R5: the tick coincides with the idle level.
    assert_tick_at_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> (sclk == cpol));

    // R7: a write that changes the divider drops the flag.
    assert_flag_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[DIV_LSB +: DW] != rd_data[DIV_LSB +: DW]) |=> !rd_data[STABLE_BIT]);

    // R8: the flag is only set while the active rate matches the programmed rate.
    assert_flag_rate_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[STABLE_BIT] |-> (act_div == div_eff));
endmodule

bind serclk_gen serclk_gen_chk #(.RW(RW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .cpol(cpol), .sclk(sclk), .bit_tick(bit_tick),
    .act_div(act_div), .div_eff(div_eff)
);

// File: tb/serclk_gen_bench.sv
module serclk_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        cpol = 1'b0;
    logic        sclk;
    logic        bit_tick;

    int n_checks = 0;
    int n_fails  = 0;
    int cur_raw  = 1;
    int seed_val;

    serclk_gen u_serclk_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .cpol(cpol), .sclk(sclk), .bit_tick(bit_tick)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int eff(input int d);
        return (d == 0) ? 1 : d;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic reg_write(input bit en, input int d, input bit junk);
        wr_en   = 1'b1;
        wr_data = {d[7:0], 6'b0, junk, en};
        step();
        wr_en   = 1'b0;
    endtask

    task automatic wait_stable();
        for (int i = 0; i < 4000 && !rd_data[1]; i++) step();
    endtask

    // Measures one full period starting at a tick (R3, R5).
    task automatic measure(input int d, input string req);
        int n = 0;
        int m = 0;
        for (int i = 0; i < 1200 && !bit_tick; i++) step();
        while (sclk == cpol && n < 600) begin n++; step(); end
        while (sclk != cpol && m < 600) begin m++; step(); end
        chk(n == eff(d), {req, " idle half"}, n, eff(d));
        chk(m == eff(d), {req, " active half"}, m, eff(d));
        chk(bit_tick == 1'b1, "R5 tick at period start", bit_tick, 1);
    endtask

    // Reprograms the divider and follows the waveform until the flag returns (R6, R7, R8).
    task automatic change_and_track(input int newd);
        int old_e = eff(cur_raw);
        int new_e = eff(newd);
        int i = 0, run = 0, last_tick = -1, iv1 = 0, iv2 = 0, nticks = 0;
        bit started = 0, seen_new = 0, prev_tick = 0, bad_order = 0, bad_len = 0;
        logic prev_lvl;
        bit changed = (newd != cur_raw);
        reg_write(1'b1, newd, 1'b0);
        cur_raw = newd;
        if (changed) chk(rd_data[1] == 1'b0, "R7 flag drops after change", rd_data[1], 0);
        else begin
            chk(rd_data[1] == 1'b1, "R7 flag kept on same value", rd_data[1], 1);
            return;
        end
        prev_lvl = sclk;
        prev_tick = bit_tick;
        if (bit_tick) begin last_tick = 0; nticks = 1; end
        while (i < 4000) begin
            step();
            i++;
            if (rd_data[1]) break;
            if (sclk != prev_lvl) begin
                if (started) begin
                    if (run != old_e && run != new_e) bad_len = 1;
                    if (run == new_e && new_e != old_e) seen_new = 1;
                    if (run == old_e && new_e != old_e && seen_new) bad_order = 1;
                end
                started = 1;
                run = 1;
            end else run++;
            prev_lvl = sclk;
            if (bit_tick) begin
                iv2 = iv1;
                iv1 = i - last_tick;
                last_tick = i;
                nticks++;
            end
            prev_tick = bit_tick;
        end
        chk(!bad_len, "R6 half length old or new", bad_len, 0);
        chk(!bad_order, "R6 no old half after new", bad_order, 0);
        chk(prev_tick == 1'b1, "R8 flag rises after tick", prev_tick, 1);
        chk(iv1 == 2*new_e && iv2 == 2*new_e, "R8 two periods at new rate", iv1, 2*new_e);
        chk(nticks >= 3, "R8 tick count before flag", nticks, 3);
        chk(i <= 2*old_e + 4*new_e + 6, "R8 settle bound", i, 2*old_e + 4*new_e + 6);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
        finish_run();
    end

    initial begin
        seed_val = $urandom(32'h5eed);
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset value, R2 idle after reset
        chk(rd_data == 16'h0100, "R1 reset value", rd_data, 16'h0100);
        chk(sclk == 1'b0 && !bit_tick, "R2 idle after reset", sclk, 0);
        cpol = 1'b1;
        repeat (10) step();
        chk(sclk == 1'b1 && !bit_tick, "R2 R9 idle high when disabled", sclk, 1);
        cpol = 1'b0;

        // R1 readback; a write to the flag bit is ignored
        reg_write(1'b1, 3, 1'b1);
        chk(rd_data[15:8] == 8'd3 && rd_data[0] && rd_data[7:2] == 6'b0,
            "R1 readback fields", rd_data, 16'h0301);
        chk(rd_data[1] == 1'b0, "R1 flag not writable", rd_data[1], 0);
        cur_raw = 3;
        wait_stable();
        chk(rd_data[1] == 1'b1, "R8 flag sets after enable", rd_data[1], 1);
        measure(3, "R3 div3");

        // R4 divider zero
        change_and_track(0);
        measure(0, "R4 div0");

        // R9 inverted polarity
        cpol = 1'b1;
        step();
        measure(0, "R9 cpol1");
        change_and_track(5);
        measure(5, "R9 R3 cpol1 div5");
        cpol = 1'b0;

        // R7 same value keeps the flag
        change_and_track(5);

        // R3 R6 R8 random changes at random phases
        for (int k = 0; k < 14; k++) begin
            int d = $urandom_range(0, 24);
            repeat ($urandom_range(0, 40)) step();
            change_and_track(d);
            measure(d, "R3 random");
        end

        // R8 largest divider
        change_and_track(255);
        measure(255, "R3 div255");
        change_and_track(2);

        // R2 disable mid-period
        repeat (3) step();
        reg_write(1'b0, 2, 1'b0);
        step();
        for (int j = 0; j < 20; j++) begin
            chk(sclk == cpol && !bit_tick, "R2 idle after disable", sclk, cpol);
            step();
        end
        finish_run();
    end
endmodule